// File: doc/BRIEF.md
# Branch and Jump Next-PC Unit

A purely combinational control-flow evaluator for a 64-bit RISC-V integer core. Each cycle it is given the address of the current instruction, the two source register values, an immediate already extracted from the instruction word, the three-bit condition field and a two-bit control-flow class. From these it decides whether control leaves the sequential path, computes the next fetch address and the return address, and flags encodings that must not execute.

Conditional branches compare the two operands as equal, not-equal, signed less-than, signed greater-or-equal, unsigned less-than or unsigned greater-or-equal. The direct jump always redirects relative to the PC. The register-indirect jump adds the immediate to the first operand and forces the lowest address bit to zero. All address arithmetic wraps modulo 2^64. The return address always comes from the PC before the jump, so a register-indirect jump that writes the same register it reads still targets from the old operand value. The unit has no state and no handshake: results are valid in the same cycle the inputs are.

Top module: `bnj_next_pc`

## Requirements
- R1: With class 01 (branch), funct3 000 is taken when the operands are equal and 001 when they differ.
- R2: Funct3 100 is taken when operand 1 is less than operand 2 as signed 64-bit values; funct3 101 is taken when it is not.
- R3: Funct3 110 is taken when operand 1 is less than operand 2 as unsigned 64-bit values; funct3 111 is taken when it is not.
- R4: Funct3 101 and 111 are taken when both operands are equal.
- R5: A taken branch gives a target of PC plus the sign-extended 32-bit immediate, wrapping modulo 2^64; a branch that is not taken gives PC + 4.
- R6: Class 10 (direct jump) is taken regardless of funct3 and operands and targets PC plus the sign-extended immediate.
- R7: Class 11 (register jump) with funct3 000 is taken and targets operand 1 plus the sign-extended immediate with bit 0 cleared.
- R8: A branch with funct3 010 or 011 raises the illegal flag, is not taken and gives a target of PC + 4.
- R9: A register jump with any funct3 other than 000 raises the illegal flag, is not taken and gives a target of PC + 4.
- R10: The link output is PC + 4 (wrapping) for every class; class 00 (no control flow) is never taken, never illegal, and targets PC + 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pc_i | input | 64 | Address of the current instruction |
| src_a_i | input | 64 | First register operand |
| src_b_i | input | 64 | Second register operand |
| imm_i | input | 32 | Decoded immediate, sign-extended inside the unit |
| cond_i | input | 3 | funct3 condition / variant field |
| kind_i | input | 2 | Class: 00 none, 01 branch, 10 direct jump, 11 register jump |
| taken_o | output | 1 | Control leaves the sequential path |
| target_o | output | 64 | Next fetch address |
| link_o | output | 64 | Return address, PC + 4 |
| illegal_o | output | 1 | Encoding is not allowed |

## Verification
Every output is due zero cycles after its inputs change, since nothing in the unit is registered. The bench applies each stimulus on the falling clock edge and samples all four outputs a nanosecond later, well before the next rising edge, so each comparison sees settled logic belonging to exactly one stimulus. Operands are drawn from a pool weighted toward equality, the signed extremes and the unsigned extremes so the signed and unsigned comparison families disagree often.

// File: rtl/bnj_pkg.sv
package bnj_pkg;
  localparam int XLEN     = 64;
  localparam int IMM_W    = 32;
  localparam int INSN_B   = 4;

  typedef enum logic [1:0] {
    KIND_NONE = 2'b00,
    KIND_BR   = 2'b01,
    KIND_JDIR = 2'b10,
    KIND_JREG = 2'b11
  } flow_kind_e;

  typedef enum logic [2:0] {
    CND_EQ  = 3'b000,
    CND_NE  = 3'b001,
    CND_RS2 = 3'b010,
    CND_RS3 = 3'b011,
    CND_LT  = 3'b100,
    CND_GE  = 3'b101,
    CND_LTU = 3'b110,
    CND_GEU = 3'b111
  } cond_e;

  typedef struct packed {
    logic eq;
    logic lt_s;
    logic lt_u;
  } cmp_flags_t;
endpackage

// File: rtl/bnj_compare.sv
module bnj_compare #(
  parameter int W = 64
) (
  input  logic [W-1:0]         a_i,
  input  logic [W-1:0]         b_i,
  output bnj_pkg::cmp_flags_t  flags_o
);
  localparam int DW = W + 1;

  logic [DW-1:0] diff;
  logic          sign_differs;

  // One shared subtractor yields the unsigned borrow; the signed result
  // reuses it unless the sign bits disagree.
  assign diff         = {1'b0, a_i} - {1'b0, b_i};
  assign sign_differs = a_i[W-1] ^ b_i[W-1];

  assign flags_o.eq   = (a_i == b_i);
  assign flags_o.lt_u = diff[DW-1];
  assign flags_o.lt_s = sign_differs ? a_i[W-1] : diff[DW-1];
endmodule

// File: rtl/bnj_cond_eval.sv
module bnj_cond_eval (
  input  bnj_pkg::flow_kind_e  kind_i,
  input  logic [2:0]           cond_i,
  input  bnj_pkg::cmp_flags_t  flags_i,
  output logic                 taken_o,
  output logic                 illegal_o
);
  import bnj_pkg::*;

  logic br_hit;
  logic br_bad;

  always_comb begin
    br_hit = 1'b0;
    br_bad = 1'b0;
    unique case (cond_e'(cond_i))
      CND_EQ:  br_hit = flags_i.eq;
      CND_NE:  br_hit = !flags_i.eq;
      CND_LT:  br_hit = flags_i.lt_s;
      CND_GE:  br_hit = !flags_i.lt_s;
      CND_LTU: br_hit = flags_i.lt_u;
      CND_GEU: br_hit = !flags_i.lt_u;
      default: br_bad = 1'b1;
    endcase
  end

  always_comb begin
    taken_o   = 1'b0;
    illegal_o = 1'b0;
    unique case (kind_i)
      KIND_NONE: begin
        taken_o   = 1'b0;
        illegal_o = 1'b0;
      end
      KIND_BR: begin
        taken_o   = br_hit && !br_bad;
        illegal_o = br_bad;
      end
      KIND_JDIR: begin
        taken_o   = 1'b1;
        illegal_o = 1'b0;
      end
      KIND_JREG: begin
        illegal_o = (cond_i != 3'b000);
        taken_o   = (cond_i == 3'b000);
      end
      default: begin
        taken_o   = 1'b0;
        illegal_o = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/bnj_addr_gen.sv
module bnj_addr_gen #(
  parameter int W     = 64,
  parameter int IW    = 32,
  parameter int STEP  = 4
) (
  input  logic [W-1:0]         pc_i,
  input  logic [W-1:0]         base_reg_i,
  input  logic [IW-1:0]        imm_i,
  input  bnj_pkg::flow_kind_e  kind_i,
  input  logic                 taken_i,
  output logic [W-1:0]         target_o,
  output logic [W-1:0]         link_o
);
  import bnj_pkg::*;

  localparam int EXT_W = W - IW;

  logic [W-1:0] imm_sx;
  logic [W-1:0] base;
  logic [W-1:0] jump_sum;
  logic [W-1:0] jump_addr;
  logic [W-1:0] seq_addr;

  generate
    if (EXT_W > 0) begin : g_sext
      assign imm_sx = {{EXT_W{imm_i[IW-1]}}, imm_i};
    end else begin : g_trunc
      assign imm_sx = imm_i[W-1:0];
    end
  endgenerate

  // Only the register jump takes its base from an operand; everything
  // else is PC-relative, so a single adder serves all classes.
  assign base      = (kind_i == KIND_JREG) ? base_reg_i : pc_i;
  assign jump_sum  = base + imm_sx;
  assign jump_addr = (kind_i == KIND_JREG) ? {jump_sum[W-1:1], 1'b0} : jump_sum;
  assign seq_addr  = pc_i + W'(STEP);

  assign target_o = taken_i ? jump_addr : seq_addr;
  assign link_o   = seq_addr;
endmodule

// File: rtl/bnj_next_pc.sv
module bnj_next_pc (
  input  logic [63:0] pc_i,
  input  logic [63:0] src_a_i,
  input  logic [63:0] src_b_i,
  input  logic [31:0] imm_i,
  input  logic [2:0]  cond_i,
  input  logic [1:0]  kind_i,
  output logic        taken_o,
  output logic [63:0] target_o,
  output logic [63:0] link_o,
  output logic        illegal_o
);
  import bnj_pkg::*;

  flow_kind_e kind;
  cmp_flags_t flags;
  logic       taken;

  assign kind = flow_kind_e'(kind_i);

  bnj_compare #(.W(XLEN)) u_cmp (
    .a_i     (src_a_i),
    .b_i     (src_b_i),
    .flags_o (flags)
  );

  bnj_cond_eval u_cond (
    .kind_i    (kind),
    .cond_i    (cond_i),
    .flags_i   (flags),
    .taken_o   (taken),
    .illegal_o (illegal_o)
  );

  bnj_addr_gen #(.W(XLEN), .IW(IMM_W), .STEP(INSN_B)) u_addr (
    .pc_i       (pc_i),
    .base_reg_i (src_a_i),
    .imm_i      (imm_i),
    .kind_i     (kind),
    .taken_i    (taken),
    .target_o   (target_o),
    .link_o     (link_o)
  );

  assign taken_o = taken;
endmodule

// File: rtl/bnj_next_pc_chk.sv
module bnj_next_pc_chk (
  input logic [63:0] src_a_i,
  input logic [63:0] src_b_i,
  input logic [2:0]  cond_i,
  input logic [1:0]  kind_i,
  input logic        taken_o,
  input logic [63:0] target_o,
  input logic [63:0] link_o,
  input logic        illegal_o
);
  always_comb begin
    // R8
    illegal_never_taken_chk: assert (!(illegal_o && taken_o));
    // R5
    seq_matches_link_chk: assert (taken_o || (target_o == link_o));
    // R6
    direct_jump_taken_chk: assert (kind_i != 2'b10 || (taken_o && !illegal_o));
    // R7
    reg_jump_even_chk: assert (!(kind_i == 2'b11 && taken_o) || !target_o[0]);
    // R4
    ge_equal_taken_chk: assert (!(kind_i == 2'b01 && cond_i[0] && cond_i[2]
                                  && (src_a_i == src_b_i)) || taken_o);
    // R10
    idle_quiet_chk: assert (kind_i != 2'b00 || (!taken_o && !illegal_o));
  end
endmodule

bind bnj_next_pc bnj_next_pc_chk u_chk (
  .src_a_i   (src_a_i),
  .src_b_i   (src_b_i),
  .cond_i    (cond_i),
  .kind_i    (kind_i),
  .taken_o   (taken_o),
  .target_o  (target_o),
  .link_o    (link_o),
  .illegal_o (illegal_o)
);

// File: tb/bnj_next_pc_test.sv
`timescale 1ns/1ps
module bnj_next_pc_test;
  logic        clk = 1'b0;
  logic [63:0] pc = '0, ra = '0, rb = '0;
  logic [31:0] imm = '0;
  logic [2:0]  cnd = '0;
  logic [1:0]  knd = '0;
  logic        taken, illegal;
  logic [63:0] target, link;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  bnj_next_pc uut (
    .pc_i(pc), .src_a_i(ra), .src_b_i(rb), .imm_i(imm), .cond_i(cnd),
    .kind_i(knd), .taken_o(taken), .target_o(target), .link_o(link),
    .illegal_o(illegal)
  );

  function automatic bit exp_illegal(input logic [1:0] k, input logic [2:0] c);
    if (k == 2'b01) return (c == 3'b010 || c == 3'b011);   // R8
    if (k == 2'b11) return (c != 3'b000);                  // R9
    return 1'b0;
  endfunction

  function automatic bit exp_taken(input logic [1:0] k, input logic [2:0] c,
                                   input logic [63:0] a, input logic [63:0] b);
    if (exp_illegal(k, c)) return 1'b0;
    case (k)
      2'b00: return 1'b0;
      2'b10: return 1'b1;
      2'b11: return 1'b1;
      default: case (c)
        3'b000: return a == b;                       // R1
        3'b001: return a != b;                       // R1
        3'b100: return $signed(a) <  $signed(b);     // R2
        3'b101: return $signed(a) >= $signed(b);     // R2 R4
        3'b110: return a <  b;                       // R3
        default: return a >= b;                      // R3 R4
      endcase
    endcase
  endfunction

  function automatic logic [63:0] exp_target(input logic [1:0] k, input logic [2:0] c,
      input logic [63:0] p, input logic [63:0] a, input logic [63:0] b, input logic [31:0] i);
    logic signed [63:0] sx;
    logic [63:0] t;
    sx = 64'($signed(i));
    if (!exp_taken(k, c, a, b)) return p + 64'd4;
    if (k == 2'b11) begin
      t = a + sx;                                     // R7
      t[0] = 1'b0;
      return t;
    end
    return p + sx;                                    // R5 R6
  endfunction

  function automatic string tag_of(input logic [1:0] k, input logic [2:0] c);
    if (k == 2'b00) return "R10";
    if (k == 2'b10) return "R6";
    if (k == 2'b11) return (c == 0) ? "R7" : "R9";
    case (c)
      3'b000, 3'b001: return "R1";
      3'b100, 3'b101: return "R2";
      3'b110, 3'b111: return "R3";
      default: return "R8";
    endcase
  endfunction

  task automatic cmp(input string req, input string what,
                     input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic apply(input logic [1:0] k, input logic [2:0] c, input logic [63:0] p,
                       input logic [63:0] a, input logic [63:0] b, input logic [31:0] i,
                       input string req);
    @(negedge clk);
    knd = k; cnd = c; pc = p; ra = a; rb = b; imm = i;
    #1;
    cmp(req, "taken",   64'(taken),   64'(exp_taken(k, c, a, b)));
    cmp(req, "illegal", 64'(illegal), 64'(exp_illegal(k, c)));
    cmp(req, "target",  target, exp_target(k, c, p, a, b, i));
    cmp("R10", "link",  link, p + 64'd4);
  endtask

  function automatic logic [63:0] pick_op(input int sel);
    case (sel)
      0: return 64'h0;
      1: return 64'h1;
      2: return 64'hFFFF_FFFF_FFFF_FFFF;
      3: return 64'h8000_0000_0000_0000;
      4: return 64'h7FFF_FFFF_FFFF_FFFF;
      5: return 64'h0000_0000_8000_0000;
      default: return {$urandom, $urandom};
    endcase
  endfunction

  initial begin
    #1;
    // reset state: all inputs zero = class none
    cmp("R10", "reset taken", 64'(taken), 64'd0);
    cmp("R10", "reset target", target, 64'd4);
    cmp("R10", "reset illegal", 64'(illegal), 64'd0);

    // directed corners
    apply(2'b01, 3'b000, 64'h1000, 64'h5, 64'h5, 32'h10, "R1");
    apply(2'b01, 3'b001, 64'h1000, 64'h5, 64'h5, 32'h10, "R1");
    apply(2'b01, 3'b100, 64'h2000, 64'h8000_0000_0000_0000, 64'h1, 32'hFFFF_FFF0, "R2");
    apply(2'b01, 3'b110, 64'h2000, 64'h8000_0000_0000_0000, 64'h1, 32'hFFFF_FFF0, "R3");
    apply(2'b01, 3'b101, 64'h3000, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 32'h8, "R4");
    apply(2'b01, 3'b111, 64'h3000, 64'h0, 64'h0, 32'h8, "R4");
    apply(2'b01, 3'b000, 64'hFFFF_FFFF_FFFF_FFF8, 64'h0, 64'h0, 32'h10, "R5");
    apply(2'b01, 3'b001, 64'hFFFF_FFFF_FFFF_FFFC, 64'h0, 64'h0, 32'h10, "R5");
    apply(2'b10, 3'b101, 64'h10, 64'h0, 64'h0, 32'hFFFF_FFE0, "R6");
    apply(2'b11, 3'b000, 64'h40, 64'h1001, 64'h0, 32'h2, "R7");
    apply(2'b11, 3'b000, 64'h40, 64'h40, 64'h0, 32'h0, "R7");
    apply(2'b01, 3'b010, 64'h80, 64'h1, 64'h1, 32'h4, "R8");
    apply(2'b01, 3'b011, 64'h80, 64'h1, 64'h2, 32'h4, "R8");
    apply(2'b11, 3'b100, 64'h80, 64'h200, 64'h0, 32'h4, "R9");
    apply(2'b00, 3'b000, 64'hFFFF_FFFF_FFFF_FFFC, 64'h1, 64'h1, 32'h4, "R10");

    // constrained random
    void'($urandom(32'd2024));
    for (int n = 0; n < 3000; n++) begin
      logic [1:0] k;
      logic [2:0] c;
      logic [63:0] a, b, p;
      logic [31:0] i;
      k = 2'($urandom_range(0, 3));
      c = 3'($urandom_range(0, 7));
      if (k == 2'b11 && $urandom_range(0, 3) != 0) c = 3'b000;
      a = pick_op($urandom_range(0, 9));
      b = ($urandom_range(0, 3) == 0) ? a : pick_op($urandom_range(0, 9));
      p = {$urandom, $urandom} & ~64'h3;
      i = $urandom;
      apply(k, c, p, a, b, i, tag_of(k, c));
    end

    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule